// File: doc/BRIEF.md
# Lockable Low-Speed Timer with Watchdog Mode

The block is a 16-bit timer that runs from a 32.768 kHz low-speed clock. It can act as a general-purpose counter or as a watchdog. Software sets it up through a small register bus with four word addresses: a load register, a read-only live count, a control register, and a clear strobe. The control register takes exactly one write after reset. Every write after that one is dropped, so a watchdog setup cannot be undone by code that has gone astray.

As a counter, the block counts up or down on prescaled ticks. It either wraps through the full 16-bit range or reloads from the load register at its terminal count and raises a sticky interrupt. In watchdog mode, a tick taken while the count is 0 produces a one-cycle reset request, or the interrupt instead if software chose that. Writing to the clear address refreshes the watchdog. A power-down input can optionally freeze the count.

Top module: `lp_wdog_timer`

## Requirements
- R1: The control register resets to 0x0000. Only the first control write after reset is accepted; later control writes leave it unchanged.
- R2: Control fields are: bit 8 up (1) or down (0), bit 7 enable, bit 6 periodic (1) or free-running (0), bit 5 watchdog, bits 3:2 prescale select, bit 1 watchdog-interrupt select, bit 0 power-down stop. All other bits read as 0 and ignore writes.
- R3: With bit 7 clear, the count holds its value and no ticks occur.
- R4: On each tick the count moves by one in the selected direction. In free-running mode it wraps from 0xFFFF to 0 when counting up, and from 0 to 0xFFFF when counting down.
- R5: In periodic mode, a tick taken at the terminal count (0 when counting down, 0xFFFF when counting up) reloads the count from the load register. If watchdog mode is off, that tick also sets the interrupt flag.
- R6: The prescale select codes are 00 = divide by 1, 01 = divide by 16, 10 = divide by 256, and 11 = divide by 1. The prescaler is held at zero while the timer is disabled, so the first tick comes one full prescale period after enable.
- R7: While the power-down input is high and bit 0 is set, both the count and the prescaler freeze. With bit 0 clear, the power-down input has no effect.
- R8: In watchdog mode with bit 1 clear, a tick taken while the count is 0 drives rst_req_o high for exactly one cycle. It does not set the interrupt.
- R9: In watchdog mode with bit 1 set, that same tick sets the interrupt flag and does not request a reset.
- R10: A write to address 3 clears the interrupt flag, but an interrupt event in the same cycle wins. In watchdog mode, that write also reloads the count from the load register.
- R11: A write to address 0 sets both the load register and the count, and it takes priority over a tick. Address 1 reads the count, address 2 reads the control register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pd_i | input | 1 | Peripheral power-down indication |
| irq_o | output | 1 | Sticky interrupt level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A behavioural model in the bench is stepped once per clock. The live count, the interrupt and the reset request are compared against it on every cycle. Separate reset sessions cover the following setups:

- **Periodic down-count:** tells reload apart from wrap.
- **Free-running up-count at divide-by-16, with power-down pulses:** tells gating apart from plain holding.
- **Divide-by-256 down-count past zero:** shows the prescale period and the underflow wrap.
- **Watchdog with periodic refreshes followed by a missed refresh:** shows reset-versus-refresh timing.
- **Watchdog in interrupt mode:** shows that the interrupt replaces the reset.
- **Disabled timer:** shows that the count holds.
- **All-ones control write:** shows the reserved bits and the reserved prescale code.

Control readback checks after second writes show the lock.

// File: rtl/lpwt_pkg.sv
package lpwt_pkg;
  localparam int          CNT_W     = 16;
  localparam logic [15:0] CTRL_MASK = 16'h01EF;
  localparam int          DIV1_SH   = 4;
  localparam int          DIV2_SH   = 8;

  typedef enum logic [1:0] {
    A_LOAD  = 2'd0,
    A_VALUE = 2'd1,
    A_CTRL  = 2'd2,
    A_CLEAR = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       up;
    logic       en;
    logic       periodic;
    logic       wd;
    logic [1:0] div_sel;
    logic       wd_irq;
    logic       pd_stop;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(logic [15:0] r);
    ctrl_t c;
    c.up       = r[8];
    c.en       = r[7];
    c.periodic = r[6];
    c.wd       = r[5];
    c.div_sel  = r[3:2];
    c.wd_irq   = r[1];
    c.pd_stop  = r[0];
    return c;
  endfunction
endpackage

// File: rtl/lpwt_ctrl_reg.sv
module lpwt_ctrl_reg
  import lpwt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] raw_o,
  output ctrl_t       ctrl_o
);
  logic [15:0] raw_q;
  logic        locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_i && !locked_q) begin
      raw_q    <= wdata_i & CTRL_MASK;
      locked_q <= 1'b1;
    end
  end

  assign raw_o  = raw_q;
  assign ctrl_o = decode_ctrl(raw_q);

  p_locked_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(raw_q));
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q & ~CTRL_MASK) == 16'h0);
endmodule

// File: rtl/lpwt_prescaler.sv
module lpwt_prescaler
  import lpwt_pkg::*;
#(
  parameter int SH1 = DIV1_SH,
  parameter int SH2 = DIV2_SH
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       run_i,
  input  logic [1:0] div_sel_i,
  output logic       tick_o
);
  localparam int PRE_W = (SH2 > SH1) ? SH2 : SH1;
  localparam logic [PRE_W-1:0] LIM1 = PRE_W'((1 << SH1) - 1);
  localparam logic [PRE_W-1:0] LIM2 = PRE_W'((1 << SH2) - 1);

  logic [PRE_W-1:0] pre_q, limit;

  always_comb begin
    unique case (div_sel_i)
      2'b01:   limit = LIM1;
      2'b10:   limit = LIM2;
      default: limit = '0;  // 00 and reserved 11
    endcase
  end

  assign tick_o = run_i && (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (!en_i)    pre_q <= '0;
    else if (tick_o)   pre_q <= '0;
    else if (run_i)    pre_q <= pre_q + 1'b1;
  end

  p_tick_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && limit != '0 && $stable(div_sel_i)) |=> !tick_o);
  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run_i) |=> $stable(pre_q));
endmodule

// File: rtl/lpwt_counter.sv
module lpwt_counter
  import lpwt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  ctrl_t        ctrl_i,
  input  logic         load_wr_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_wr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] load_o,
  output logic         irq_o,
  output logic         rst_req_o
);
  logic [W-1:0] cnt_q, load_q, nxt;
  logic         irq_q, rst_q, at_term, at_zero, wd_fire, per_fire;

  assign at_zero  = (cnt_q == '0);
  assign at_term  = ctrl_i.up ? (cnt_q == '1) : at_zero;
  assign wd_fire  = tick_i && ctrl_i.wd && at_zero;
  assign per_fire = tick_i && !ctrl_i.wd && ctrl_i.periodic && at_term;

  always_comb begin
    if (at_term && ctrl_i.periodic) nxt = load_q;
    else if (ctrl_i.up)             nxt = cnt_q + 1'b1;
    else                            nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= '0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (load_wr_i) load_q <= load_val_i;
      if (load_wr_i)                    cnt_q <= load_val_i;
      else if (clr_wr_i && ctrl_i.wd)   cnt_q <= load_q;
      else if (tick_i)                  cnt_q <= nxt;
      if (per_fire || (wd_fire && ctrl_i.wd_irq)) irq_q <= 1'b1;
      else if (clr_wr_i)                         irq_q <= 1'b0;
      rst_q <= wd_fire && !ctrl_i.wd_irq;
    end
  end

  assign cnt_o     = cnt_q;
  assign load_o    = load_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_wr_i && !clr_wr_i) |=> $stable(cnt_q));
  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> cnt_q == $past(load_val_i));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctrl_i.periodic && at_term && !load_wr_i && !clr_wr_i)
      |=> cnt_q == $past(load_q));
  p_rst_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  p_irq_not_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> !ctrl_i.wd_irq);
  p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_wr_i) |=> irq_q);
endmodule

// File: rtl/lp_wdog_timer.sv
module lp_wdog_timer
  import lpwt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         pd_i,
  output logic         irq_o,
  output logic         rst_req_o
);
  logic [15:0]  ctrl_raw;
  ctrl_t        ctrl;
  logic         run, tick, load_wr, ctrl_wr, clr_wr;
  logic [W-1:0] cnt, load_q;

  assign load_wr = wr_en_i && (addr_i == A_LOAD);
  assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
  assign clr_wr  = wr_en_i && (addr_i == A_CLEAR);

  lpwt_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .wr_i(ctrl_wr), .wdata_i(wdata_i[15:0]),
    .raw_o(ctrl_raw), .ctrl_o(ctrl)
  );

  assign run = ctrl.en && !(ctrl.pd_stop && pd_i);

  lpwt_prescaler u_pre (
    .clk_i, .rst_ni, .en_i(ctrl.en), .run_i(run),
    .div_sel_i(ctrl.div_sel), .tick_o(tick)
  );

  lpwt_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ctrl_i(ctrl),
    .load_wr_i(load_wr), .load_val_i(wdata_i), .clr_wr_i(clr_wr),
    .cnt_o(cnt), .load_o(load_q), .irq_o, .rst_req_o
  );

  always_comb begin
    unique case (addr_i)
      A_LOAD:  rdata_o = load_q;
      A_VALUE: rdata_o = cnt;
      A_CTRL:  rdata_o = W'(ctrl_raw);
      default: rdata_o = '0;
    endcase
  end

  p_pd_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.pd_stop && pd_i) |-> !tick);
  p_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |-> !tick);
endmodule

// File: tb/lp_wdog_timer_tb.sv
`timescale 1ns/100ps
module lp_wdog_timer_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0, pd = 0;
  logic [1:0]  addr = 2'd1;
  logic [15:0] wdata = '0, rdata;
  logic        irq, rst_req;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_wdog_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pd_i(pd), .irq_o(irq), .rst_req_o(rst_req)
  );

  // behavioural reference
  int m_ctrl, m_load, m_cnt, m_pre, m_lock;
  bit m_irq, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_load = 0; m_cnt = 0; m_pre = 0; m_lock = 0; m_irq = 0; m_rst = 0;
    end else begin
      bit en, run, tick, up, per, wd, set, term;
      int dv, nc;
      en  = m_ctrl[7]; up = m_ctrl[8]; per = m_ctrl[6]; wd = m_ctrl[5];
      run = en && !(m_ctrl[0] && pd);
      dv  = (((m_ctrl >> 2) & 3) == 1) ? 16 : (((m_ctrl >> 2) & 3) == 2) ? 256 : 1;
      tick = run && (m_pre == dv - 1);
      set = 0; nc = m_cnt;
      m_rst = 0;
      if (tick) begin
        term = up ? (m_cnt == 65535) : (m_cnt == 0);
        if (wd && m_cnt == 0) begin
          if (m_ctrl[1]) set = 1; else m_rst = 1;
        end
        if (!wd && per && term) set = 1;
        if (term && per) nc = m_load;
        else nc = up ? (m_cnt + 1) % 65536 : (m_cnt + 65535) % 65536;
      end
      if (!en) m_pre = 0;
      else if (run) m_pre = tick ? 0 : m_pre + 1;
      if (wr_en && addr == 0) begin m_load = wdata; nc = wdata; end
      else if (wr_en && addr == 3 && wd) nc = m_load;
      if (set) m_irq = 1; else if (wr_en && addr == 3) m_irq = 0;
      if (wr_en && addr == 2 && !m_lock) begin m_ctrl = wdata & 16'h01EF; m_lock = 1; end
      m_cnt = nc;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (!wr_en && addr == 2'd1 && rdata != 16'(m_cnt)) begin
      n_bad++; $display("FAIL %s count: actual %h expected %h", tag, rdata, 16'(m_cnt));
    end
    if (irq !== m_irq) begin
      n_bad++; $display("FAIL %s irq: actual %b expected %b", tag, irq, m_irq);
    end
    if (rst_req !== m_rst) begin
      n_bad++; $display("FAIL %s rst_req: actual %b expected %b", tag, rst_req, m_rst);
    end
  end

  task automatic do_reset();
    @(negedge clk); #0.5; rst_n = 0; wr_en = 0; pd = 0; addr = 2'd1;
    @(negedge clk); #0.5; rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); #0.5; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #0.5; wr_en = 0; addr = 2'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [15:0] exp, input string t);
    @(negedge clk); #0.5; addr = a; #0.5;
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++; $display("FAIL %s readback: actual %h expected %h", t, rdata, exp);
    end
    #0.5; addr = 2'd1;
  endtask

  initial begin
    #150000;
    n_bad++; $display("FAIL watchdog: run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    tag = "R1_reset";
    chk_rd(2'd2, 16'h0000, "R1");
    chk_rd(2'd3, 16'h0000, "R11");
    // periodic down-count, div1
    tag = "R5";
    wr(2'd0, 16'd5);
    chk_rd(2'd0, 16'd5, "R11");
    wr(2'd2, 16'h00C0);
    idle(15);
    tag = "R10";
    wr(2'd3, 16'h0);
    idle(3);
    tag = "R1_lock";
    wr(2'd2, 16'h01C0);
    chk_rd(2'd2, 16'h00C0, "R1");
    idle(10);
    tag = "R11";
    wr(2'd0, 16'd2);
    idle(6);
    // disabled timer holds
    do_reset();
    tag = "R3";
    wr(2'd0, 16'd9);
    wr(2'd2, 16'h0100);
    idle(40);
    // free-running up, div16, pd stop
    do_reset();
    tag = "R4";
    wr(2'd0, 16'hFFFD);
    wr(2'd2, 16'h0185);
    idle(60);
    tag = "R7";
    @(negedge clk); #0.5; pd = 1;
    idle(40);
    @(negedge clk); #0.5; pd = 0;
    idle(50);
    // div256 down, free-running underflow
    do_reset();
    tag = "R6";
    wr(2'd0, 16'd2);
    wr(2'd2, 16'h0088);
    idle(800);
    // watchdog reset mode, pd ignored
    do_reset();
    tag = "R8";
    wr(2'd0, 16'd10);
    wr(2'd2, 16'h00A0);
    for (int i = 0; i < 4; i++) begin
      idle(5);
      tag = "R10_refresh";
      wr(2'd3, 16'h0);
    end
    tag = "R7_nostop";
    @(negedge clk); #0.5; pd = 1;
    idle(6);
    @(negedge clk); #0.5; pd = 0;
    tag = "R8";
    idle(20);
    // watchdog irq mode
    do_reset();
    tag = "R9";
    wr(2'd0, 16'd6);
    wr(2'd2, 16'h00A2);
    idle(12);
    tag = "R10";
    wr(2'd3, 16'h0);
    idle(10);
    // reserved bits and code 11
    do_reset();
    tag = "R2";
    wr(2'd0, 16'hFFF0);
    wr(2'd2, 16'hFFFF);
    chk_rd(2'd2, 16'h01EF, "R2");
    idle(40);
    wr(2'd2, 16'h0000);
    chk_rd(2'd2, 16'h01EF, "R1");
    idle(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule